// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block decides when a capture engine should fire its trigger. It runs a small programmable state machine over a stream of samples. Each sample is a data word plus a few single-bit signals, and each carries a valid strobe. The machine has a number of levels. At any moment one level is current, and only that level looks at the arriving sample.

Every level holds up to four branches, and each branch has its own condition. A condition can be one of three tests: a masked equality compare on the sample word, a rising edge on one chosen single-bit signal, or an elapsed test on a shared sample timer. Each branch also has an action set, made of any mix of these: fire the trigger, jump to a chosen level, and start the timer.

When several branches of the current level are true on the same sample, the lowest-indexed branch wins. A jump takes effect for the next sample, so a single sample can never satisfy two levels. After the trigger has fired, the sequencer stays silent until it is armed again.

Top module: `trig_sequencer`

## Requirements
- R1: A one-cycle `arm` pulse makes level 0 current, stops the timer and allows a new trigger. A sample presented in the same cycle as `arm` is not evaluated, and `trig_out` stays low in the following cycle.
- R2: Before the first arm, or in any cycle without `sample_valid`, the current level does not change and no trigger is produced.
- R3: When no branch of the current level is true for a valid sample, the same level evaluates the next valid sample.
- R4: A branch of kind 1 (masked compare) is true when `((sample_word ^ value) & mask) == 0`. Bits with a mask bit of 0 are ignored.
- R5: A branch of kind 2 (rising edge) is true when `edge_in[sel]` is 1 on this valid sample and was 0 on the previous valid sample. The remembered value is 0 after reset, and it is updated on every valid sample whether or not the sequencer is armed. Kind 0 is never true.
- R6: A branch of kind 3 (timer) is true when the timer is running and the j-th valid sample after the start sample has j >= `tmr_limit`. The start action restarts the count even when the timer is already running. The count saturates.
- R7: If the winning branch has its jump enable set, the next valid sample is evaluated at the jump target. Otherwise the level stays the same.
- R8: The level reached by a jump first evaluates the next later valid sample. With level 0 = "upper byte 0x10, jump to 1" and level 1 = "lower byte 0x20, trigger", the sample 0x1020 does not trigger. A later 0x3320 does.
- R9: When several branches of the current level are true, only the actions of the lowest-indexed one are taken.
- R10: A winning branch with the trigger action drives `trig_out` high for exactly the one cycle after the sample's clock edge. The current level is then frozen, and no further trigger is produced until the next `arm`.
- R11: Branch configuration b of level l occupies `lvl_cfg[(l*N_BRANCH+b)*BR_W +: BR_W]`. With the default widths its fields, from bit 0 upward, are: kind[1:0], mask[17:2], value[33:18], sel[35:34], trigger[36], jump enable[37], jump target[39:38], timer start[40].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Restart pulse for the sequence |
| sample_valid | input | 1 | Marks a sample as present this cycle |
| sample_word | input | DATA_W | Sampled address/data word |
| edge_in | input | EDGE_W | Single-bit signals watched for rising edges |
| tmr_limit | input | TMR_W | Elapsed threshold for timer conditions |
| lvl_cfg | input | N_LEVELS*N_BRANCH*BR_W | Packed branch configurations |
| trig_out | output | 1 | One-cycle trigger pulse |
| cur_level | output | LVL_W | Index of the current level |

## Verification
On every cycle, the assertions check several properties. The level holds while no sample arrives. An arm always returns the sequencer to level 0 with no pulse. A pulse never repeats without a new arm. The winning branch is at most one-hot and follows branch 0. A timer start loads the count with one.

The condition kinds themselves can only be shown by the bench's scenarios, through the sequences they drive. These include masked compares that ignore masked bits, edge detection that must skip bits that were already high, and the timer's exact sample count. The same holds for the one-sample-per-level ordering in the address/data example, and for jump priority across branches.

// File: rtl/trig_seq_pkg.sv
`timescale 1ns/1ps
package trig_seq_pkg;

  typedef enum logic [1:0] {
    CK_NEVER = 2'd0,
    CK_MATCH = 2'd1,
    CK_RISE  = 2'd2,
    CK_TIMER = 2'd3
  } cond_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;

  // masked equality on zero-extended operands
  function automatic logic masked_equal(input logic [63:0] smp,
                                        input logic [63:0] val,
                                        input logic [63:0] msk);
    return ((smp ^ val) & msk) == 64'd0;
  endfunction

  // saturating increment on a 32-bit container, bounded by max
  function automatic logic [31:0] sat_inc(input logic [31:0] cur,
                                          input logic [31:0] max);
    return (cur >= max) ? max : cur + 32'd1;
  endfunction

endpackage

// File: rtl/trig_branch_eval.sv
`timescale 1ns/1ps
module trig_branch_eval
  import trig_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EDGE_W = 4,
  parameter int LVL_W  = 2,
  localparam int SEL_W = (EDGE_W > 1) ? $clog2(EDGE_W) : 1,
  localparam int BR_W  = 2 + 2*DATA_W + SEL_W + 3 + LVL_W
)(
  input  logic [BR_W-1:0]   br_cfg,
  input  logic [DATA_W-1:0] sample_word,
  input  logic [EDGE_W-1:0] rise_vec,
  input  logic              tmr_elapsed,
  output logic              hit,
  output logic              act_trig,
  output logic              act_goto_en,
  output logic [LVL_W-1:0]  act_goto,
  output logic              act_tstart
);
  localparam int OFS_MASK  = 2;
  localparam int OFS_VALUE = OFS_MASK + DATA_W;
  localparam int OFS_SEL   = OFS_VALUE + DATA_W;
  localparam int OFS_TRIG  = OFS_SEL + SEL_W;
  localparam int OFS_GEN   = OFS_TRIG + 1;
  localparam int OFS_GOTO  = OFS_GEN + 1;
  localparam int OFS_TST   = OFS_GOTO + LVL_W;

  cond_kind_e        kind;
  logic [DATA_W-1:0] mask_f;
  logic [DATA_W-1:0] value_f;
  logic [SEL_W-1:0]  sel_f;
  logic              match_hit;
  logic              rise_hit;

  assign kind        = cond_kind_e'(br_cfg[1:0]);
  assign mask_f      = br_cfg[OFS_MASK +: DATA_W];
  assign value_f     = br_cfg[OFS_VALUE +: DATA_W];
  assign sel_f       = br_cfg[OFS_SEL +: SEL_W];
  assign act_trig    = br_cfg[OFS_TRIG];
  assign act_goto_en = br_cfg[OFS_GEN];
  assign act_goto    = br_cfg[OFS_GOTO +: LVL_W];
  assign act_tstart  = br_cfg[OFS_TST];

  assign match_hit = masked_equal(64'(sample_word), 64'(value_f), 64'(mask_f));

  always_comb begin
    rise_hit = 1'b0;
    for (int i = 0; i < EDGE_W; i++) begin
      if (32'(sel_f) == i) rise_hit = rise_vec[i];
    end
  end

  always_comb begin
    unique case (kind)
      CK_MATCH: hit = match_hit;
      CK_RISE:  hit = rise_hit;
      CK_TIMER: hit = tmr_elapsed;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/trig_prio_pick.sv
`timescale 1ns/1ps
module trig_prio_pick #(
  parameter int N_BRANCH = 4
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_BRANCH-1:0] hits,
  output logic [N_BRANCH-1:0] grant,
  output logic                any_hit
);
  always_comb begin
    grant = '0;
    for (int i = N_BRANCH - 1; i >= 0; i--) begin
      if (hits[i]) grant = N_BRANCH'(1) << i;
    end
  end

  assign any_hit = |grant;

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9
  branch0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hits[0] |-> grant[0]);

endmodule

// File: rtl/trig_sample_timer.sv
`timescale 1ns/1ps
module trig_sample_timer
  import trig_seq_pkg::*;
#(
  parameter int TMR_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             start,
  input  logic             step,
  input  logic [TMR_W-1:0] limit,
  output logic             elapsed
);
  localparam logic [31:0] CNT_MAX = 32'((64'd1 << TMR_W) - 64'd1);

  logic             running;
  logic [TMR_W-1:0] count;
  logic             load_ev;
  logic             tick_ev;

  assign load_ev = !clear && start;
  assign tick_ev = !clear && !start && step && running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
    end else if (clear) begin
      running <= 1'b0;
      count   <= '0;
    end else if (load_ev) begin
      running <= 1'b1;
      count   <= TMR_W'(1);
    end else if (tick_ev) begin
      count   <= TMR_W'(sat_inc(32'(count), CNT_MAX));
    end
  end

  assign elapsed = running && (count >= limit);

  // R6
  tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (running && count == TMR_W'(1)));

  // R1
  tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !running);

  // R6
  tmr_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !clear && !start) |=> count >= $past(count));

endmodule

// File: rtl/trig_sequencer.sv
`timescale 1ns/1ps
module trig_sequencer
  import trig_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int EDGE_W   = 4,
  parameter int N_LEVELS = 4,
  parameter int N_BRANCH = 4,
  parameter int TMR_W    = 8,
  localparam int SEL_W    = (EDGE_W > 1) ? $clog2(EDGE_W) : 1,
  localparam int LVL_W    = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1,
  localparam int BR_W     = 2 + 2*DATA_W + SEL_W + 3 + LVL_W,
  localparam int LVL_BITS = N_BRANCH * BR_W,
  localparam int CFG_W    = N_LEVELS * LVL_BITS
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] sample_word,
  input  logic [EDGE_W-1:0] edge_in,
  input  logic [TMR_W-1:0]  tmr_limit,
  input  logic [CFG_W-1:0]  lvl_cfg,
  output logic              trig_out,
  output logic [LVL_W-1:0]  cur_level
);
  seq_state_e        state;
  logic [EDGE_W-1:0] edge_prev;
  logic [EDGE_W-1:0] rise_vec;
  logic [LVL_BITS-1:0] lvl_slice;
  logic              tmr_elapsed;

  logic [N_BRANCH-1:0] hits;
  logic [N_BRANCH-1:0] grant;
  logic                any_hit;
  logic [N_BRANCH-1:0] b_trig;
  logic [N_BRANCH-1:0] b_gen;
  logic [N_BRANCH-1:0] b_tst;
  logic [LVL_W-1:0]    b_goto [N_BRANCH];

  // named internal events
  logic             eval_en;
  logic             take;
  logic             fire;
  logic             tmr_start;
  logic             w_gen;
  logic [LVL_W-1:0] w_goto;
  logic [LVL_W-1:0] level_nxt;

  assign rise_vec = edge_in & ~edge_prev;

  always_comb begin
    lvl_slice = '0;
    for (int l = 0; l < N_LEVELS; l++) begin
      if (32'(cur_level) == l) lvl_slice = lvl_cfg[l*LVL_BITS +: LVL_BITS];
    end
  end

  for (genvar b = 0; b < N_BRANCH; b++) begin : g_branch
    trig_branch_eval #(
      .DATA_W(DATA_W),
      .EDGE_W(EDGE_W),
      .LVL_W (LVL_W)
    ) u_eval (
      .br_cfg     (lvl_slice[b*BR_W +: BR_W]),
      .sample_word(sample_word),
      .rise_vec   (rise_vec),
      .tmr_elapsed(tmr_elapsed),
      .hit        (hits[b]),
      .act_trig   (b_trig[b]),
      .act_goto_en(b_gen[b]),
      .act_goto   (b_goto[b]),
      .act_tstart (b_tst[b])
    );
  end

  trig_prio_pick #(.N_BRANCH(N_BRANCH)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .hits   (hits),
    .grant  (grant),
    .any_hit(any_hit)
  );

  assign eval_en = (state == SQ_RUN) && sample_valid && !arm;
  assign take    = eval_en && any_hit;

  always_comb begin
    fire      = 1'b0;
    tmr_start = 1'b0;
    w_gen     = 1'b0;
    w_goto    = '0;
    for (int b = 0; b < N_BRANCH; b++) begin
      if (grant[b]) begin
        fire      = take && b_trig[b];
        tmr_start = take && b_tst[b];
        w_gen     = b_gen[b];
        w_goto    = b_goto[b];
      end
    end
  end

  always_comb begin
    level_nxt = cur_level;
    if (take && w_gen && (32'(w_goto) < N_LEVELS)) level_nxt = w_goto;
  end

  trig_sample_timer #(.TMR_W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (arm),
    .start  (tmr_start),
    .step   (sample_valid),
    .limit  (tmr_limit),
    .elapsed(tmr_elapsed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_prev <= '0;
    else if (sample_valid) edge_prev <= edge_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      cur_level <= '0;
      trig_out  <= 1'b0;
    end else begin
      trig_out <= fire;
      if (arm) begin
        state     <= SQ_RUN;
        cur_level <= '0;
      end else if (fire) begin
        state     <= SQ_DONE;
      end else if (take) begin
        cur_level <= level_nxt;
      end
    end
  end

  // R1
  arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (cur_level == '0 && !trig_out));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !arm) |=> ($stable(cur_level) && !trig_out));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_DONE && !arm) |=> !trig_out);

  // R10
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(sample_valid));

  // R7
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cur_level) < N_LEVELS);

endmodule

// File: tb/sim_trig_sequencer.sv
`timescale 1ns/1ps
module sim_trig_sequencer;
  localparam int DATA_W   = 16;
  localparam int EDGE_W   = 4;
  localparam int N_LEVELS = 4;
  localparam int N_BRANCH = 4;
  localparam int TMR_W    = 8;
  localparam int SEL_W    = 2;
  localparam int LVL_W    = 2;
  localparam int BR_W     = 2 + 2*DATA_W + SEL_W + 3 + LVL_W;
  localparam int CFG_W    = N_LEVELS * N_BRANCH * BR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              arm = 1'b0;
  logic              sample_valid = 1'b0;
  logic [DATA_W-1:0] sample_word = '0;
  logic [EDGE_W-1:0] edge_in = '0;
  logic [TMR_W-1:0]  tmr_limit = '0;
  logic [CFG_W-1:0]  lvl_cfg = '0;
  logic              trig_out;
  logic [LVL_W-1:0]  cur_level;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  always #5 clk = ~clk;

  trig_sequencer #(
    .DATA_W(DATA_W), .EDGE_W(EDGE_W), .N_LEVELS(N_LEVELS),
    .N_BRANCH(N_BRANCH), .TMR_W(TMR_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .sample_valid(sample_valid),
    .sample_word(sample_word), .edge_in(edge_in), .tmr_limit(tmr_limit),
    .lvl_cfg(lvl_cfg), .trig_out(trig_out), .cur_level(cur_level)
  );

  always @(negedge clk) if (trig_out) pulses++;

  // R11 field order, bit 0 upward: kind, mask, value, sel, trig, jump en, target, tstart
  function automatic logic [BR_W-1:0] mk(input logic [1:0] kind,
      input logic [15:0] mask, input logic [15:0] value, input logic [1:0] sel,
      input logic trig, input logic gen, input logic [1:0] tgt, input logic tst);
    return {tst, tgt, gen, trig, sel, value, mask, kind};
  endfunction

  task automatic set_br(input int l, input int b, input logic [BR_W-1:0] v);
    lvl_cfg[(l*N_BRANCH+b)*BR_W +: BR_W] = v;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input logic [3:0] e);
    sample_word = w; edge_in = e; sample_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(posedge clk); @(negedge clk);
    arm = 1'b0;
    chk("R1 level after arm", 32'(cur_level), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset trig", 32'(trig_out), 0);
    chk("R1 reset level", 32'(cur_level), 0);
  endtask

  task automatic t_unarmed();
    lvl_cfg = '0;
    set_br(0, 0, mk(2'd1, 16'h0000, 16'h0, 2'd0, 1'b1, 1'b1, 2'd1, 1'b0));
    send(16'h1234, 4'h0);
    chk("R2 unarmed trig", 32'(trig_out), 0);
    chk("R2 unarmed level", 32'(cur_level), 0);
  endtask

  task automatic t_addr_data();
    lvl_cfg = '0;
    set_br(0, 0, mk(2'd1, 16'hFF00, 16'h1000, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0));
    set_br(1, 0, mk(2'd1, 16'h00FF, 16'h0020, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0));
    do_arm();
    send(16'h1020, 4'h0);
    chk("R8 no trig on first sample", 32'(trig_out), 0);
    chk("R7 jumped to level 1", 32'(cur_level), 1);
    send(16'h1130, 4'h0);
    chk("R3 stay on false", 32'(cur_level), 1);
    chk("R3 no trig on false", 32'(trig_out), 0);
    send(16'h3320, 4'h0);
    chk("R8 trig on later data", 32'(trig_out), 1);
    chk("R10 level frozen", 32'(cur_level), 1);
    send(16'h4420, 4'h0);
    chk("R10 no second trig", 32'(trig_out), 0);
    chk("R10 single pulse count", 32'(pulses), 1);
  endtask

  task automatic t_mask();
    lvl_cfg = '0;
    set_br(0, 0, mk(2'd1, 16'h0F0F, 16'h0305, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0));
    do_arm();
    send(16'hF3A4, 4'h0);
    chk("R4 unmasked bit differs", 32'(trig_out), 0);
    send(16'hF3A5, 4'h0);
    chk("R4 masked bits ignored", 32'(trig_out), 1);
  endtask

  task automatic t_priority();
    lvl_cfg = '0;
    set_br(0, 0, mk(2'd1, 16'h0000, 16'h0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b0));
    set_br(0, 1, mk(2'd1, 16'h0000, 16'h0, 2'd0, 1'b1, 1'b1, 2'd1, 1'b0));
    set_br(2, 0, mk(2'd1, 16'hFFFF, 16'h5555, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0));
    set_br(2, 1, mk(2'd1, 16'h0000, 16'h0, 2'd0, 1'b0, 1'b1, 2'd3, 1'b0));
    set_br(3, 0, mk(2'd1, 16'h0000, 16'h0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0));
    do_arm();
    send(16'h0001, 4'h0);
    chk("R9 branch 0 wins", 32'(cur_level), 2);
    chk("R9 branch 1 trig not taken", 32'(trig_out), 0);
    send(16'h1234, 4'h0);
    chk("R9 next branch when 0 false", 32'(cur_level), 3);
    // arm together with a matching sample
    sample_word = 16'h0000; sample_valid = 1'b1;
    do_arm();
    sample_valid = 1'b0;
    chk("R1 sample with arm ignored", 32'(trig_out), 0);
  endtask

  task automatic t_edge();
    lvl_cfg = '0;
    set_br(0, 0, mk(2'd2, 16'h0, 16'h0, 2'd2, 1'b0, 1'b1, 2'd1, 1'b0));
    set_br(1, 0, mk(2'd2, 16'h0, 16'h0, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0));
    send(16'h0, 4'h0);
    do_arm();
    send(16'h0, 4'b0100);
    chk("R5 rise moves to level 1", 32'(cur_level), 1);
    send(16'h0, 4'b0100);
    chk("R5 held high is no edge", 32'(trig_out), 0);
    send(16'h0, 4'b0000);
    send(16'h0, 4'b1011);
    chk("R5 other bits ignored", 32'(trig_out), 0);
    send(16'h0, 4'b0100);
    chk("R5 rise fires", 32'(trig_out), 1);
  endtask

  task automatic t_timer();
    lvl_cfg = '0;
    tmr_limit = 8'd3;
    set_br(0, 0, mk(2'd1, 16'hFFFF, 16'h00AA, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1));
    set_br(0, 1, mk(2'd3, 16'h0, 16'h0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0));
    do_arm();
    send(16'h0011, 4'h0);
    chk("R6 not running no hit", 32'(trig_out), 0);
    send(16'h00AA, 4'h0);
    chk("R7 no jump stays", 32'(cur_level), 0);
    send(16'h0011, 4'h0);
    chk("R6 j=1 below limit", 32'(trig_out), 0);
    send(16'h0011, 4'h0);
    chk("R6 j=2 below limit", 32'(trig_out), 0);
    send(16'h0011, 4'h0);
    chk("R6 j=3 reaches limit", 32'(trig_out), 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_addr_data();
    t_mask();
    t_priority();
    t_edge();
    t_timer();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule